// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block provides three independent 16-bit down-counters behind a byte-wide register interface. A 2-bit address picks one of four ports. Ports 0, 1 and 2 are the data ports of channels 0 to 2. Port 3 takes control words. Each channel keeps a stored control setting, a reload value, a live count, an optional latched snapshot and a pending status request. It counts in either binary or four-digit BCD.

The counters step down on a shared count-enable tick. When a channel reaches terminal count it reloads and pulses its output for one clock, which makes it a rate generator. Software programs a channel with a control word and then one or two data bytes. A data-port read returns one of three things: the live count, a snapshot taken by a latch command, or a status byte. A read-back command on the control port can latch the counts or arm status reads on several channels at once. Channel 2 counts only while the gate input is high.

Top module: `interval_timer3`

## Requirements
- R1: A control word is decoded as follows. Bits 7:6 select the channel, and the value 3 means read-back. Bits 5:4 give the access mode. Bits 3:1 give the counting mode, which is only stored and reported. Bit 0 selects BCD (1) or binary (0).
- R2: A control word with access mode 1, 2 or 3 stores bits 5:0 for the selected channel and clears its reload value to zero. It sets null count, clears any latch, pending status and both byte toggles, and leaves the live count untouched. While null count is set, the channel does not count.
- R3: Data writes depend on the access mode. Mode 1 replaces the low reload byte and mode 2 the high reload byte. Mode 3 takes the low byte and then the high byte, tracked by a write toggle. When programming completes (after one byte in modes 1 and 2, after the second byte in mode 3), the reload value is copied into the count and null count clears.
- R4: Data reads depend on the access mode. Mode 1 returns bits 7:0 of the value and mode 2 returns bits 15:8. Mode 3 returns the low byte and then the high byte, using a read toggle that is independent of the write toggle.
- R5: A control word with access mode 0 copies the selected channel's count into its latch, unless a latch is already pending, in which case the command has no effect. Reads return the latched value until the final byte has been read (the single byte in modes 1 and 2, the high byte in mode 3), and that read releases the latch. A latch command issued in the same cycle as a tick captures the count from before the decrement.
- R6: A control word with bits 7:6 = 3 is a read-back. If bit 5 is 0, it latches the count of every channel whose select bit is set: bit 1 for channel 0, bit 2 for channel 1 and bit 3 for channel 2. If bit 4 is 0, it arms a status read on those channels.
- R7: While a status read is armed, the next data read of that channel returns a status byte: bit 7 is the output level, bit 6 is null count and bits 5:0 are the stored control bits. That read clears the request. It does not move the read toggle or release a latch.
- R8: On each tick, a counting channel decrements by one. A tick that finds the count at 1 instead loads the reload value and drives that channel's output high for exactly the following clock. A reload value of 0 gives the full range: 65536 ticks in binary, 10000 in BCD.
- R9: In binary mode a count of 0 decrements to 0xFFFF. In BCD mode each nibble is one decimal digit, 0 decrements to 0x9999, and 0x0010 decrements to 0x0009.
- R10: Channel 2 ignores ticks while the gate input is low. Channels 0 and 1 have no gate.
- R11: After reset every channel holds control bits 0x34 (access mode 3, counting mode 2, binary), a count of 0, a reload value of 0, no latch, no status request and null count clear. The outputs and the read data are 0.
- R12: Read data is registered. It appears the clock after the read strobe and holds until the next read. A read of port 3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable pulse shared by all channels |
| gate | input | 1 | Count enable for channel 2 only |
| addr | input | 2 | Port select: 0-2 data ports, 3 control port |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| rd | input | 1 | Read strobe, sampled on the clock edge |
| rdata | output | 8 | Registered read data |
| tc_out | output | 3 | One-clock terminal-count pulse per channel |

## Verification
A counter-latch command and a counter decrement can land on the same clock edge. In that case the snapshot must hold the value from before the tick, while the live count moves on. The bench provokes this by driving a control-port latch write and a tick in the same cycle on a channel loaded with 8. It then reads the channel twice in single-byte mode: the first read must return 8 from the latch and release it, and the second must return the live value 7. A second overlap is a null-count channel that receives ticks, which must leave the count frozen. This is judged by reading the count before and after the ticks and by reading the status byte.

// File: rtl/interval_timer3.sv
module interval_timer3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       gate,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  output logic [2:0] tc_out
);
  localparam int NCH = 3;
  localparam logic [5:0] CTRL_RST = 6'h34;

  logic [NCH-1:0][5:0]  ctrl_q;
  logic [NCH-1:0][15:0] cnt_q, rld_q, lat_q, nr, nxt;
  logic [NCH-1:0]       latv_q, stat_q, null_q, rtog_q, wtog_q, out_q, done, run;
  logic [7:0]           rdata_q, rbyte;
  logic [1:0]           ix, cw_sel, cw_acc;
  logic [15:0]          rv;

  assign cw_sel = wdata[7:6];
  assign cw_acc = wdata[5:4];
  assign rdata  = rdata_q;
  assign tc_out = out_q;

  function automatic logic [15:0] dec_cnt(input logic [15:0] v, input logic bcd);
    logic brw;
    dec_cnt = v - 16'd1;
    if (bcd) begin
      brw = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (!brw) dec_cnt[4*i +: 4] = v[4*i +: 4];
        else if (v[4*i +: 4] == 4'd0) dec_cnt[4*i +: 4] = 4'd9;
        else begin
          dec_cnt[4*i +: 4] = v[4*i +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      run[c] = !null_q[c] && ((c != 2) || gate);
      nxt[c] = (cnt_q[c] == 16'd1) ? rld_q[c] : dec_cnt(cnt_q[c], ctrl_q[c][0]);
      nr[c]  = rld_q[c];
      done[c] = 1'b0;
      case (ctrl_q[c][5:4])
        2'd1: begin nr[c][7:0] = wdata; done[c] = 1'b1; end
        2'd2: begin nr[c][15:8] = wdata; done[c] = 1'b1; end
        2'd3: if (wtog_q[c]) begin nr[c][15:8] = wdata; done[c] = 1'b1; end
              else nr[c][7:0] = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    ix = (addr == 2'd3) ? 2'd0 : addr;
    rv = latv_q[ix] ? lat_q[ix] : cnt_q[ix];
    if (addr == 2'd3) rbyte = 8'hFF;
    else if (stat_q[ix]) rbyte = {out_q[ix], null_q[ix], ctrl_q[ix]};
    else begin
      case (ctrl_q[ix][5:4])
        2'd1: rbyte = rv[7:0];
        2'd2: rbyte = rv[15:8];
        2'd3: rbyte = rtog_q[ix] ? rv[15:8] : rv[7:0];
        default: rbyte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
      for (int c = 0; c < NCH; c++) begin
        ctrl_q[c] <= CTRL_RST;
        cnt_q[c]  <= 16'h0;
        rld_q[c]  <= 16'h0;
        lat_q[c]  <= 16'h0;
        latv_q[c] <= 1'b0;
        stat_q[c] <= 1'b0;
        null_q[c] <= 1'b0;
        rtog_q[c] <= 1'b0;
        wtog_q[c] <= 1'b0;
        out_q[c]  <= 1'b0;
      end
    end else begin
      if (rd) rdata_q <= rbyte;
      for (int c = 0; c < NCH; c++) begin
        out_q[c] <= tick && run[c] && (cnt_q[c] == 16'd1);
        if (tick && run[c]) cnt_q[c] <= nxt[c];

        if (rd && addr == 2'(c)) begin
          if (stat_q[c]) stat_q[c] <= 1'b0;
          else begin
            case (ctrl_q[c][5:4])
              2'd1, 2'd2: latv_q[c] <= 1'b0;
              2'd3: begin
                rtog_q[c] <= !rtog_q[c];
                if (rtog_q[c]) latv_q[c] <= 1'b0;
              end
              default: ;
            endcase
          end
        end

        if (wr && addr == 2'(c) && ctrl_q[c][5:4] != 2'd0) begin
          rld_q[c]  <= nr[c];
          null_q[c] <= !done[c];
          wtog_q[c] <= (ctrl_q[c][5:4] == 2'd3) && !done[c];
          if (done[c]) cnt_q[c] <= nr[c];
        end

        if (wr && addr == 2'd3) begin
          if (cw_sel == 2'd3) begin
            if (!wdata[5] && wdata[1+c] && !latv_q[c]) begin
              latv_q[c] <= 1'b1;
              lat_q[c]  <= cnt_q[c];
            end
            if (!wdata[4] && wdata[1+c]) stat_q[c] <= 1'b1;
          end else if (cw_sel == 2'(c)) begin
            if (cw_acc == 2'd0) begin
              if (!latv_q[c]) begin
                latv_q[c] <= 1'b1;
                lat_q[c]  <= cnt_q[c];
              end
            end else begin
              ctrl_q[c] <= wdata[5:0];
              rld_q[c]  <= 16'h0;
              null_q[c] <= 1'b1;
              latv_q[c] <= 1'b0;
              stat_q[c] <= 1'b0;
              rtog_q[c] <= 1'b0;
              wtog_q[c] <= 1'b0;
            end
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_null_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (null_q[g] && !(wr && addr == 2'(g))) |=> $stable(cnt_q[g]));
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (latv_q[g] && !(wr && addr == 2'd3)) |=> (lat_q[g] == $past(lat_q[g])));
    assert_out_terminal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_q[g] |-> ($past(cnt_q[g]) == 16'd1));
    assert_status_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == 2'(g) && stat_q[g] && !(wr && addr == 2'd3)) |=> !stat_q[g]);
    assert_toggle_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[g][5:4] != 2'd3) |-> (!rtog_q[g] && !wtog_q[g]));
  end
endmodule

// File: tb/sim_interval_timer3.sv
`timescale 1ns/1ps
module sim_interval_timer3;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [2:0] tc_out;
  int checks = 0, fails = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  interval_timer3 u0 (.clk, .rst_n, .tick, .gate, .addr, .wdata, .wr, .rd, .rdata, .tc_out);

  // {req[7:0], nibble: bit3 = read-check, bits1:0 = port, data or expected byte}
  localparam int NV = 39;
  localparam logic [19:0] VEC [NV] = '{
    20'h03_3_14, 20'h03_0_34, 20'h04_8_34,                // R3 R4 single low byte
    20'h03_3_74, 20'h03_1_CD, 20'h03_1_AB,                // R3 low/high write
    20'h04_9_CD, 20'h04_9_AB, 20'h04_9_CD,                // R4 low/high read
    20'h03_1_11, 20'h04_9_AB, 20'h03_1_22,                // R4 toggles independent
    20'h04_9_11, 20'h04_9_22,
    20'h03_3_A4, 20'h03_2_56, 20'h04_A_56,                // R3 R4 high byte only
    20'h06_3_E2, 20'h07_8_14, 20'h07_8_34,                // R6 R7 status, toggle kept
    20'h02_3_74, 20'h06_3_E4, 20'h07_9_74,                // R2 R7 null count in status
    20'h05_3_40, 20'h03_1_99, 20'h03_1_88,                // R5 latch then reprogram
    20'h05_9_11, 20'h05_9_22, 20'h05_9_99, 20'h05_9_88,
    20'h05_3_80, 20'h03_2_77, 20'h05_3_80,                // R5 second latch ignored
    20'h05_A_56, 20'h05_A_77,
    20'h06_3_C8, 20'h07_A_24, 20'h06_A_77,                // R6 R1 latch+status together
    20'h0C_B_FF                                           // R12 control port read
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_port(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic do_tick(output logic [2:0] o);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; o = tc_out;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    checks++; fails++;
    finish_run;
  end

  initial begin
    logic [7:0] b;
    logic [2:0] o;
    int n;
    repeat (3) @(negedge clk);
    check(11, rdata, 8'h00);            // R11 read data after reset
    check(11, tc_out, 3'b000);          // R11 outputs after reset
    rst_n = 1'b1;
    rd_port(2'd0, b); check(11, b, 8'h00);  // R11 count 0, low
    rd_port(2'd0, b); check(11, b, 8'h00);  // R11 high
    wr_port(2'd3, 8'hE2);
    rd_port(2'd0, b); check(11, b, 8'h34);  // R11 reset control bits

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11]) begin
        rd_port(VEC[i][9:8], b);
        check(int'(VEC[i][19:12]), b, VEC[i][7:0]);
      end else wr_port(VEC[i][9:8], VEC[i][7:0]);
    end

    // R8 terminal count, reload and one-clock pulse
    wr_port(2'd3, 8'h14); wr_port(2'd0, 8'h03);
    do_tick(o); check(8, o[0], 1'b0);
    rd_port(2'd0, b); check(8, b, 8'h02);
    do_tick(o); do_tick(o); check(8, o[0], 1'b1);
    @(negedge clk); check(8, tc_out[0], 1'b0);
    rd_port(2'd0, b); check(8, b, 8'h03);

    // R2 null count halts counting
    wr_port(2'd3, 8'h14);
    do_tick(o); do_tick(o);
    rd_port(2'd0, b); check(2, b, 8'h03);
    wr_port(2'd3, 8'hE2);
    rd_port(2'd0, b); check(2, b, 8'h54);
    // R9 binary wrap
    wr_port(2'd0, 8'h00); do_tick(o);
    rd_port(2'd0, b); check(9, b, 8'hFF);

    // R9 BCD borrow and wrap
    wr_port(2'd3, 8'h55); wr_port(2'd1, 8'h10); do_tick(o);
    rd_port(2'd1, b); check(9, b, 8'h09);
    wr_port(2'd1, 8'h00); do_tick(o);
    rd_port(2'd1, b); check(9, b, 8'h99);
    wr_port(2'd3, 8'h65);
    rd_port(2'd1, b); check(9, b, 8'h99);

    // R8 full range in BCD: 10000 ticks
    wr_port(2'd3, 8'h55); wr_port(2'd1, 8'h00);
    n = 0;
    @(negedge clk); tick = 1'b1;
    for (int i = 1; i <= 12000; i++) begin
      @(posedge clk); #1;
      if (tc_out[1]) begin n = i; break; end
    end
    @(negedge clk); tick = 1'b0;
    check(8, n, 10000);

    // R10 gate on channel 2
    wr_port(2'd3, 8'h94); wr_port(2'd2, 8'h05);
    gate = 1'b0;
    do_tick(o); do_tick(o); do_tick(o);
    rd_port(2'd2, b); check(10, b, 8'h05);
    gate = 1'b1; do_tick(o);
    rd_port(2'd2, b); check(10, b, 8'h04);

    // R5 latch in the same cycle as a tick
    wr_port(2'd3, 8'h14); wr_port(2'd0, 8'h08);
    @(negedge clk); wr = 1'b1; addr = 2'd3; wdata = 8'h00; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_port(2'd0, b); check(5, b, 8'h08);
    rd_port(2'd0, b); check(5, b, 8'h07);
    // R12 read data holds without a strobe
    repeat (3) @(negedge clk);
    check(12, rdata, 8'h07);

    finish_run;
  end
endmodule